// File: doc/BRIEF.md
# Bit-addressable internal data memory

This block is the on-chip data store of a small 8-bit controller. Its 256-byte address space is split in two. The lower half is 128 bytes of general RAM. The upper half is a window of special-function registers. Only the locations a parameter mask marks as present hold storage; the rest read as zero. Three access paths work in parallel, and each can read and write in the same cycle:

- a byte port that addresses the whole space;
- a register port, whose 3-bit index plus a 2-bit bank number selects one of the four eight-byte banks at the bottom of RAM;
- a bit port with its own 8-bit bit-address space.

The bit-address space covers two areas. The lower half of it lies in the sixteen RAM bytes at 20h–2Fh. The upper half lies in every special-function register whose byte address is a multiple of eight. A bit set, clear or write reads the containing byte, changes one bit and stores the byte again, all within one clock. All read data is registered and appears one cycle after the address. It shows the contents as they stood before that cycle's writes.

Top module: `iram_bitmem`

## Requirements
- R1: After reset every RAM byte and every implemented special-function register holds 00h, and all three read outputs are 0.
- R2: A byte-port write to any address 00h–7Fh stores the data. A byte read returns, on the following cycle, the content as it was before any write in the same cycle.
- R3: The register port reaches byte address bank_sel×8 + reg_idx (00h–1Fh) for both reads and writes.
- R4: Bit addresses 00h–7Fh select byte 20h + bit_addr[6:3], bit bit_addr[2:0]. Bytes 30h–7Fh are never reached by the bit port.
- R5: Bit addresses 80h–FFh select byte address bit_addr with bits [2:0] cleared, bit bit_addr[2:0]. Special-function registers at other addresses are not reachable by the bit port.
- R6: bit_op encoding: 0 = read only, 1 = set, 2 = clear, 3 = write bit_wval. A modifying operation completes in one clock and leaves the other seven bits of the byte unchanged.
- R7: bit_rdata gives, one cycle later, the addressed bit as it was before that cycle's writes.
- R8: Upper-half addresses absent from the mask read 00h on both ports, and writes to them have no effect. By default 80h–83h, 87h–8Dh, 90h, 98h, 99h, A0h, A8h, B0h, B8h, D0h, E0h and F0h are present.
- R9: When several ports write the same byte in one cycle, the byte port wins over the register port, and the register port wins over the bit port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 2 | Register bank number for the register port |
| by_addr | input | 8 | Byte-port address |
| by_wr_en | input | 1 | Byte-port write enable |
| by_wdata | input | 8 | Byte-port write data |
| by_rdata | output | 8 | Byte-port read data, one cycle after address |
| reg_idx | input | 3 | Register index within the selected bank |
| reg_wr_en | input | 1 | Register-port write enable |
| reg_wdata | input | 8 | Register-port write data |
| reg_rdata | output | 8 | Register-port read data, one cycle after index |
| bit_addr | input | 8 | Bit address |
| bit_op | input | 2 | Bit operation (0 read, 1 set, 2 clear, 3 write) |
| bit_wval | input | 1 | Value stored by bit operation 3 |
| bit_rdata | output | 1 | Addressed bit, one cycle after address |

## Verification
A byte write and a bit modification can fall on the same byte in the same clock, and a byte write can also coincide with a register write on a bank byte. The bench drives both ports together onto one byte, in RAM and in the register window. It then reads the byte back and expects exactly the byte-port data, with no trace of the bit change. A reference model applies the bit, register and byte updates in rising priority. That model judges these cases and a long stream of mixed random traffic on all three ports.

// File: rtl/iram_pkg.sv
`timescale 1ns/1ps
package iram_pkg;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int OFF_W     = ADDR_W - 1;
    localparam int HALF      = 2 ** OFF_W;
    localparam int BIT_IDX_W = $clog2(DATA_W);
    localparam int BANK_W    = 2;
    localparam int REG_W     = 3;
    localparam int NWR       = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    localparam addr_t BITRAM_BASE = addr_t'(8'h20);

    typedef enum logic [1:0] {
        BOP_NONE = 2'd0,
        BOP_SET  = 2'd1,
        BOP_CLR  = 2'd2,
        BOP_PUT  = 2'd3
    } bit_op_e;

    typedef struct packed {
        logic  en;
        addr_t addr;
        byte_t data;
    } wr_req_t;

    function automatic logic [HALF-1:0] default_sfr_mask();
        logic [HALF-1:0] m;
        for (int i = 0; i < HALF; i++) begin
            case (i)
                0, 1, 2, 3, 7, 8, 9, 10, 11, 12, 13,
                16, 24, 25, 32, 40, 48, 56, 80, 96, 112: m[i] = 1'b1;
                default:                                 m[i] = 1'b0;
            endcase
        end
        return m;
    endfunction

    localparam logic [HALF-1:0] SFR_MASK_DEF = default_sfr_mask();
endpackage

// File: rtl/iram_bit_decode.sv
`timescale 1ns/1ps
module iram_bit_decode import iram_pkg::*; (
    input  logic [ADDR_W-1:0]    bit_addr,
    input  logic [BANK_W-1:0]    bank_sel,
    input  logic [REG_W-1:0]     reg_idx,
    output logic [ADDR_W-1:0]    bit_byte,
    output logic [BIT_IDX_W-1:0] bit_sel,
    output logic [ADDR_W-1:0]    reg_byte
);
    always_comb begin
        bit_sel = bit_addr[BIT_IDX_W-1:0];
        if (bit_addr[ADDR_W-1]) begin
            bit_byte = {bit_addr[ADDR_W-1:BIT_IDX_W], {BIT_IDX_W{1'b0}}};
        end else begin
            bit_byte = BITRAM_BASE + addr_t'(bit_addr[OFF_W-1:BIT_IDX_W]);
        end
        reg_byte = addr_t'({bank_sel, reg_idx});
    end
endmodule

// File: rtl/iram_store.sv
`timescale 1ns/1ps
module iram_store import iram_pkg::*; #(
    parameter bit              REGION = 1'b0,
    parameter logic [HALF-1:0] IMPL   = {HALF{1'b1}}
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  wr_req_t [NWR-1:0]            wr,
    output logic [HALF-1:0][DATA_W-1:0]  mem_q
);
    typedef struct packed {
        logic [HALF-1:0][DATA_W-1:0] mem;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int p = NWR - 1; p >= 0; p--) begin
            if (wr[p].en && (wr[p].addr[ADDR_W-1] == REGION)) begin
                st_d.mem[wr[p].addr[OFF_W-1:0]] = wr[p].data;
            end
        end
        for (int i = 0; i < HALF; i++) begin
            if (!IMPL[i]) begin
                st_d.mem[i] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_q = st_q.mem;
endmodule

// File: rtl/iram_bitmem.sv
`timescale 1ns/1ps
module iram_bitmem import iram_pkg::*; #(
    parameter logic [HALF-1:0] SFR_IMPL = SFR_MASK_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bank_sel,
    input  logic [7:0]        by_addr,
    input  logic              by_wr_en,
    input  logic [7:0]        by_wdata,
    output logic [7:0]        by_rdata,
    input  logic [2:0]        reg_idx,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [7:0]        bit_addr,
    input  logic [1:0]        bit_op,
    input  logic              bit_wval,
    output logic              bit_rdata
);
    typedef struct packed {
        byte_t by;
        byte_t rg;
        logic  bt;
    } out_t;

    logic [ADDR_W-1:0]           bit_byte;
    logic [BIT_IDX_W-1:0]        bit_sel;
    logic [ADDR_W-1:0]           reg_byte;
    logic [HALF-1:0][DATA_W-1:0] ram_q;
    logic [HALF-1:0][DATA_W-1:0] sfr_q;
    wr_req_t [NWR-1:0]           wr;
    byte_t                       cur_by, cur_rg, cur_bt, new_bt;
    bit_op_e                     op;
    out_t                        out_d, out_q;

    iram_bit_decode u_dec (
        .bit_addr (bit_addr),
        .bank_sel (bank_sel),
        .reg_idx  (reg_idx),
        .bit_byte (bit_byte),
        .bit_sel  (bit_sel),
        .reg_byte (reg_byte)
    );

    assign op = bit_op_e'(bit_op);

    always_comb begin
        cur_by = by_addr[ADDR_W-1]  ? sfr_q[by_addr[OFF_W-1:0]]  : ram_q[by_addr[OFF_W-1:0]];
        cur_rg = reg_byte[ADDR_W-1] ? sfr_q[reg_byte[OFF_W-1:0]] : ram_q[reg_byte[OFF_W-1:0]];
        cur_bt = bit_byte[ADDR_W-1] ? sfr_q[bit_byte[OFF_W-1:0]] : ram_q[bit_byte[OFF_W-1:0]];
        new_bt = cur_bt;
        case (op)
            BOP_SET: new_bt[bit_sel] = 1'b1;
            BOP_CLR: new_bt[bit_sel] = 1'b0;
            BOP_PUT: new_bt[bit_sel] = bit_wval;
            default: new_bt = cur_bt;
        endcase
    end

    // index 0 has the highest priority inside the stores
    always_comb begin
        wr[0] = '{en: by_wr_en,          addr: by_addr,  data: by_wdata};
        wr[1] = '{en: reg_wr_en,         addr: reg_byte, data: reg_wdata};
        wr[2] = '{en: (op != BOP_NONE),  addr: bit_byte, data: new_bt};
    end

    iram_store #(
        .REGION (1'b0),
        .IMPL   ({HALF{1'b1}})
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr),
        .mem_q (ram_q)
    );

    iram_store #(
        .REGION (1'b1),
        .IMPL   (SFR_IMPL)
    ) u_sfr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr),
        .mem_q (sfr_q)
    );

    always_comb begin
        out_d    = out_q;
        out_d.by = cur_by;
        out_d.rg = cur_rg;
        out_d.bt = cur_bt[bit_sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign by_rdata  = out_q.by;
    assign reg_rdata = out_q.rg;
    assign bit_rdata = out_q.bt;
endmodule

// File: rtl/iram_bitmem_chk.sv
`timescale 1ns/1ps
module iram_bitmem_chk #(
    parameter logic [127:0] SFR_IMPL = '1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       bank_sel,
    input logic [7:0]       by_addr,
    input logic             by_wr_en,
    input logic [7:0]       by_wdata,
    input logic [7:0]       by_rdata,
    input logic [2:0]       reg_idx,
    input logic             reg_wr_en,
    input logic [7:0]       reg_wdata,
    input logic [7:0]       bit_addr,
    input logic [1:0]       bit_op,
    input logic             bit_rdata,
    input logic [127:0][7:0] ram_q,
    input logic [127:0][7:0] sfr_q,
    input logic [7:0]       bit_byte
);
    logic [6:0] bidx;
    logic [7:0] bcur;
    logic       no_other_wr;

    assign bidx        = {3'b010, bit_addr[6:3]};
    assign bcur        = ram_q[bidx];
    assign no_other_wr = !by_wr_en && !reg_wr_en;

    AST_BYTE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        by_wr_en && !by_addr[7] |=> ram_q[$past(by_addr[6:0])] == $past(by_wdata)); // R2

    AST_REG_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en && !(by_wr_en && by_addr == {3'b000, bank_sel, reg_idx})
        |=> ram_q[$past({bank_sel, reg_idx})] == $past(reg_wdata)); // R3

    AST_BIT_SET_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        bit_op == 2'd1 && !bit_addr[7] && no_other_wr
        |=> ram_q[$past(bidx)] == ($past(bcur) | (8'd1 << $past(bit_addr[2:0])))); // R6

    AST_BIT_CLR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        bit_op == 2'd2 && !bit_addr[7] && no_other_wr
        |=> ram_q[$past(bidx)] == ($past(bcur) & ~(8'd1 << $past(bit_addr[2:0])))); // R6

    AST_BIT_READ_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_addr[7] |=> bit_rdata == $past(bcur[bit_addr[2:0]])); // R7

    AST_UNIMPL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        by_addr[7] && !SFR_IMPL[by_addr[6:0]] |=> by_rdata == 8'h00); // R8

    AST_BYTE_BEATS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        by_wr_en && bit_op != 2'd0 && bit_byte == by_addr
        |=> ($past(by_addr[7]) ? sfr_q[$past(by_addr[6:0])] : ram_q[$past(by_addr[6:0])])
            == (($past(by_addr[7]) && !SFR_IMPL[$past(by_addr[6:0])]) ? 8'h00 : $past(by_wdata))); // R9
endmodule

bind iram_bitmem iram_bitmem_chk #(.SFR_IMPL(SFR_IMPL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_sel  (bank_sel),
    .by_addr   (by_addr),
    .by_wr_en  (by_wr_en),
    .by_wdata  (by_wdata),
    .by_rdata  (by_rdata),
    .reg_idx   (reg_idx),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .bit_addr  (bit_addr),
    .bit_op    (bit_op),
    .bit_rdata (bit_rdata),
    .ram_q     (ram_q),
    .sfr_q     (sfr_q),
    .bit_byte  (bit_byte)
);

// File: tb/test_iram_bitmem.sv
`timescale 1ns/1ps
module test_iram_bitmem;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bank_sel = '0;
    logic [7:0] by_addr = '0, by_wdata = '0, by_rdata;
    logic       by_wr_en = 1'b0;
    logic [2:0] reg_idx = '0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic [7:0] bit_addr = '0;
    logic [1:0] bit_op = '0;
    logic       bit_wval = 1'b0, bit_rdata;

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        bit         cb, cr, ct;
        logic [7:0] eb, er;
        logic       et;
        string      tag;
    } item_t;

    item_t      sb[$];
    logic [7:0] mdl [256];

    always #2.5 clk = ~clk;

    iram_bitmem i_iram_bitmem (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
        .by_addr(by_addr), .by_wr_en(by_wr_en), .by_wdata(by_wdata), .by_rdata(by_rdata),
        .reg_idx(reg_idx), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bit_addr(bit_addr), .bit_op(bit_op), .bit_wval(bit_wval), .bit_rdata(bit_rdata)
    );

    // R8: present upper-half locations
    function automatic bit present(input logic [7:0] a);
        if (!a[7]) return 1'b1;
        case (a)
            8'h80, 8'h81, 8'h82, 8'h83, 8'h87, 8'h88, 8'h89, 8'h8A, 8'h8B,
            8'h8C, 8'h8D, 8'h90, 8'h98, 8'h99, 8'hA0, 8'hA8, 8'hB0, 8'hB8,
            8'hD0, 8'hE0, 8'hF0: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit bw, input logic [7:0] ba, input logic [7:0] bd,
                       input bit rw, input logic [1:0] bk, input logic [2:0] ri, input logic [7:0] rd,
                       input logic [1:0] op, input logic [7:0] bta, input bit btv,
                       input bit cb, input bit cr, input bit ct, input string tag);
        logic [7:0] rb, bb, nb;
        logic [2:0] bs;
        item_t it;
        @(negedge clk);
        by_wr_en = bw; by_addr = ba; by_wdata = bd;
        reg_wr_en = rw; bank_sel = bk; reg_idx = ri; reg_wdata = rd;
        bit_op = op; bit_addr = bta; bit_wval = btv;
        rb = {3'b000, bk, ri};                                   // R3
        bb = bta[7] ? {bta[7:3], 3'b000} : 8'h20 + {4'h0, bta[6:3]}; // R4 R5
        bs = bta[2:0];
        it.cb = cb; it.cr = cr; it.ct = ct; it.tag = tag;
        it.eb = mdl[ba]; it.er = mdl[rb]; it.et = mdl[bb][bs];
        sb.push_back(it);
        nb = mdl[bb];
        case (op)
            2'd1: nb[bs] = 1'b1;
            2'd2: nb[bs] = 1'b0;
            2'd3: nb[bs] = btv;
            default: ;
        endcase
        if (op != 2'd0 && present(bb)) mdl[bb] = nb;   // lowest priority
        if (rw && present(rb)) mdl[rb] = rd;
        if (bw && present(ba)) mdl[ba] = bd;           // R9 highest
    endtask

    task automatic bytew(input logic [7:0] a, input logic [7:0] d);
        cyc(1, a, d, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    endtask
    task automatic byter(input logic [7:0] a, input string tag);
        cyc(0, a, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, tag);
    endtask
    task automatic regw(input logic [1:0] bk, input logic [2:0] i, input logic [7:0] d);
        cyc(0, 0, 0, 1, bk, i, d, 0, 0, 0, 0, 0, 0, "");
    endtask
    task automatic regr(input logic [1:0] bk, input logic [2:0] i, input string tag);
        cyc(0, 0, 0, 0, bk, i, 0, 0, 0, 0, 0, 1, 0, tag);
    endtask
    task automatic bitop(input logic [1:0] op, input logic [7:0] a, input bit v);
        cyc(0, 0, 0, 0, 0, 0, 0, op, a, v, 0, 0, 0, "");
    endtask
    task automatic bitr(input logic [7:0] a, input string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, a, 0, 0, 0, 1, tag);
    endtask

    // monitor: one expected item per driven cycle, sampled after the edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            if (it.cb) chk({it.tag, " byte"}, by_rdata, it.eb);
            if (it.cr) chk({it.tag, " reg"}, reg_rdata, it.er);
            if (it.ct) chk({it.tag, " bit"}, {7'b0, bit_rdata}, {7'b0, it.et});
        end
    end

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 by_rdata", by_rdata, 8'h00);
        chk("R1 reg_rdata", reg_rdata, 8'h00);
        chk("R1 bit_rdata", {7'b0, bit_rdata}, 8'h00);
        byter(8'h00, "R1"); regr(0, 0, "R1"); bitr(8'h00, "R1"); byter(8'hE0, "R1");

        // R2 byte port, read shows pre-write content
        bytew(8'h45, 8'h3C); byter(8'h45, "R2");
        bytew(8'h7F, 8'hC3); byter(8'h7F, "R2");
        cyc(1, 8'h45, 8'h99, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R2 same-cycle");
        byter(8'h45, "R2");

        // R3 bank mapping
        for (int b = 0; b < 4; b++) regw(2'(b), 3'd5, 8'h50 + 8'(b));
        byter(8'h05, "R3"); byter(8'h0D, "R3"); byter(8'h15, "R3"); byter(8'h1D, "R3");
        regr(2, 5, "R3");
        bytew(8'h1A, 8'h77); regr(3, 2, "R3");

        // R4 RAM bit area
        bitop(1, 8'h00, 0); byter(8'h20, "R4");
        bitop(1, 8'h7F, 0); byter(8'h2F, "R4");
        bytew(8'h2A, 8'hA5);
        bitr(8'h50, "R4"); bitr(8'h51, "R4"); bitr(8'h57, "R4");
        bytew(8'h30, 8'h5A); bitop(1, 8'h02, 0); byter(8'h30, "R4");

        // R6 modify one bit, keep others
        bitop(3, 8'h13, 1); byter(8'h22, "R6");
        bitop(2, 8'h52, 0); byter(8'h2A, "R6");
        bitop(3, 8'h55, 0); byter(8'h2A, "R6");

        // R7 bit read sees old value in the modifying cycle
        cyc(0, 0, 0, 0, 0, 0, 0, 2'd1, 8'h01, 0, 0, 0, 1, "R7 old");
        bitr(8'h01, "R7");

        // R5 register-window bits
        bitop(1, 8'hE3, 0); byter(8'hE0, "R5");
        bytew(8'h88, 8'hFF); bitop(2, 8'h8F, 0); byter(8'h88, "R5");
        bytew(8'h81, 8'h42); bitop(2, 8'h89, 0); byter(8'h81, "R5"); byter(8'h88, "R5");

        // R8 absent locations
        bytew(8'h84, 8'hAA); byter(8'h84, "R8");
        bitop(1, 8'hF9, 0); bitr(8'hF9, "R8"); byter(8'hF8, "R8");
        bytew(8'hFF, 8'h11); byter(8'hFF, "R8");

        // R9 same-byte collisions
        cyc(1, 8'h21, 8'h0F, 0, 0, 0, 0, 2'd1, 8'h0F, 0, 0, 0, 0, "");
        byter(8'h21, "R9");
        cyc(1, 8'h21, 8'hF0, 0, 0, 0, 0, 2'd2, 8'h0C, 0, 0, 0, 0, "");
        byter(8'h21, "R9");
        cyc(1, 8'hE0, 8'h00, 0, 0, 0, 0, 2'd1, 8'hE7, 0, 0, 0, 0, "");
        byter(8'hE0, "R9");
        cyc(1, 8'h09, 8'h11, 1, 1, 1, 8'h22, 0, 0, 0, 0, 0, 0, "");
        byter(8'h09, "R9");

        // mixed random traffic on all ports
        for (int k = 0; k < 600; k++) begin
            logic [31:0] r1, r2;
            r1 = $urandom; r2 = $urandom;
            cyc(r1[0], r1[15:8], r1[23:16], r1[1], r1[3:2], r1[6:4], r2[7:0],
                r2[9:8], (r2[10] ? {3'b001, r2[15:11]} : r2[23:16]), r2[24],
                1, 1, 1, "R9 random");
        end

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule